// File: doc/BRIEF.md
# Receiver Wakeup Filter

This block sits next to a UART receiver on a shared multi-drop line. When software decides that the traffic on the line is not meant for this node, it asks the block to sleep. While the node is asleep, the filter holds back the received-frame notifications, so the host sees no traffic. The filter also watches the line and clears the sleep state by itself when the chosen wake condition occurs.

Two wake methods are offered. The first is an idle line: the line stays high for a whole character time. The second is an address mark: a received frame arrives with its most significant data bit set. Idle time is counted in bit-time ticks supplied by the receiver. Counting can begin right after a start bit or only after a stop bit. While the node is awake, the idle period also produces a one-cycle idle-detected pulse.

The receiver supplies the per-frame events:
- a start pulse,
- a frame-done pulse with the data word and its top bit,
- a tick per bit time, together with the sampled line level.

Top module: `wake_filter`

## Requirements
- R1: After reset, asleep_o, rx_vld_o and idle_det_o are all 0.
- R2: While awake, a frame_done_i pulse appears on rx_vld_o one cycle later, with rx_data_o equal to the frame_data_i that was present with the pulse.
- R3: A sleep_req_i pulse sets asleep_o from the next cycle on. While asleep, frames are not delivered on rx_vld_o, except as R5 allows.
- R4: With wake_sel_i = 0 (idle-line wake), a completed idle period while asleep clears asleep_o in the next cycle and raises no idle_det_o pulse.
- R5: With wake_sel_i = 1 (address-mark wake), a frame with frame_msb_i = 1 received while asleep clears asleep_o and is itself delivered on rx_vld_o. A frame with frame_msb_i = 0 stays blocked. With wake_sel_i = 0, frame_msb_i has no effect on sleep.
- R6: An idle period is 10 consecutive high bit ticks when nine_bit_i = 0, and 11 when nine_bit_i = 1. idle_det_o pulses for one cycle in the cycle after the final tick.
- R7: With idle_type_i = 0, idle counting is armed by start_i. With idle_type_i = 1, it is armed by frame_done_i, and start_i disarms it. Ticks seen while disarmed never complete an idle period.
- R8: A bit tick with line_i = 0 resets the idle count to zero.
- R9: idle_det_o pulses at most once per arming. Further high ticks raise nothing until a new arming event occurs.
- R10: If sleep_req_i and a wake condition occur in the same cycle, asleep_o stays 1. A frame delivered by R5 in that cycle is still passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req_i | input | 1 | Pulse that puts the node to sleep |
| wake_sel_i | input | 1 | Wake method: 0 idle line, 1 address mark |
| idle_type_i | input | 1 | Idle count arming: 0 after start bit, 1 after stop bit |
| nine_bit_i | input | 1 | Frame format: 0 eight data bits, 1 nine data bits |
| start_i | input | 1 | Start bit detected by the receiver |
| bit_tick_i | input | 1 | One pulse per bit time |
| line_i | input | 1 | Sampled line level with the tick |
| frame_done_i | input | 1 | Frame received, data valid on frame_data_i |
| frame_data_i | input | DATA_W | Received data word |
| frame_msb_i | input | 1 | Most significant data bit of the frame |
| asleep_o | output | 1 | Sleep status |
| rx_vld_o | output | 1 | Gated received-data valid |
| rx_data_o | output | DATA_W | Delivered data word |
| idle_det_o | output | 1 | One-cycle idle-line detected pulse |

## Verification
The bench builds the block with its defaults: a 9-bit data word, idle lengths of 10 and 11 ticks, and registered outputs. With these values, both frame formats and both idle arming points can be reached from ports only. The bench steps through:
- counts of 9 and 10 high ticks on either side of the short idle length,
- the eleventh tick of the long length,
- a low tick inside a count,
- the same-cycle clash between a sleep request and an address-mark wake.

// File: rtl/wkf_pkg.sv
package wkf_pkg;
   typedef enum logic {
      WAKE_IDLE = 1'b0,
      WAKE_ADDR = 1'b1
   } wake_mode_e;
endpackage

// File: rtl/wkf_idle_counter.sv
module wkf_idle_counter #(
   parameter int IDLE_SHORT = 10,
   parameter int IDLE_LONG  = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic idle_type_i,
   input  logic nine_bit_i,
   input  logic start_i,
   input  logic frame_done_i,
   input  logic bit_tick_i,
   input  logic line_i,
   output logic idle_hit_o
);
   localparam int CNT_W = $clog2(IDLE_LONG + 1);
   localparam logic [CNT_W-1:0] LAST_S = CNT_W'(IDLE_SHORT - 1);
   localparam logic [CNT_W-1:0] LAST_L = CNT_W'(IDLE_LONG - 1);

   logic             armed_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;
   logic             arm_evt;
   logic             disarm_evt;

   assign last       = nine_bit_i ? LAST_L : LAST_S;
   assign arm_evt    = idle_type_i ? frame_done_i : start_i;
   assign disarm_evt = idle_type_i & start_i;
   assign idle_hit_o = armed_q & bit_tick_i & line_i & (cnt_q == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
      end else if (arm_evt) begin
         armed_q <= 1'b1;
      end else if (disarm_evt || idle_hit_o) begin
         armed_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start_i || !armed_q) begin
         cnt_q <= '0;
      end else if (bit_tick_i) begin
         if (!line_i || idle_hit_o) cnt_q <= '0;
         else                       cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/wkf_sleep_ctrl.sv
module wkf_sleep_ctrl
   import wkf_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_req_i,
   input  logic wake_sel_i,
   input  logic frame_done_i,
   input  logic frame_msb_i,
   input  logic idle_hit_i,
   output logic asleep_o,
   output logic pass_o,
   output logic idle_det_o
);
   wake_mode_e mode;
   logic       addr_hit;
   logic       wake;
   logic       asleep_q;
   logic       idle_q;

   assign mode     = wake_mode_e'(wake_sel_i);
   assign addr_hit = (mode == WAKE_ADDR) & frame_done_i & frame_msb_i;
   assign wake     = (mode == WAKE_ADDR) ? addr_hit : idle_hit_i;
   assign pass_o   = frame_done_i & (!asleep_q | addr_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         asleep_q <= 1'b0;
      end else if (sleep_req_i) begin
         asleep_q <= 1'b1;
      end else if (asleep_q && wake) begin
         asleep_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idle_q <= 1'b0;
      else        idle_q <= idle_hit_i & !asleep_q;
   end

   assign asleep_o   = asleep_q;
   assign idle_det_o = idle_q;
endmodule

// File: rtl/wkf_data_gate.sv
module wkf_data_gate #(
   parameter int DATA_W  = 9,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pass_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              vld_o,
   output logic [DATA_W-1:0] data_o
);
   generate
      if (REG_OUT) begin : g_reg
         logic              vld_q;
         logic [DATA_W-1:0] data_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q  <= 1'b0;
               data_q <= '0;
            end else begin
               vld_q <= pass_i;
               if (pass_i) data_q <= data_i;
            end
         end
         assign vld_o  = vld_q;
         assign data_o = data_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign vld_o  = pass_i;
         assign data_o = data_i;
      end
   endgenerate
endmodule

// File: rtl/wake_filter.sv
module wake_filter #(
   parameter int DATA_W     = 9,
   parameter int IDLE_SHORT = 10,
   parameter int IDLE_LONG  = 11,
   parameter bit REG_OUT    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep_req_i,
   input  logic              wake_sel_i,
   input  logic              idle_type_i,
   input  logic              nine_bit_i,
   input  logic              start_i,
   input  logic              bit_tick_i,
   input  logic              line_i,
   input  logic              frame_done_i,
   input  logic [DATA_W-1:0] frame_data_i,
   input  logic              frame_msb_i,
   output logic              asleep_o,
   output logic              rx_vld_o,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              idle_det_o
);
   initial begin
      if (DATA_W < 2)               $error("DATA_W must be at least 2");
      if (IDLE_SHORT < 2)           $error("IDLE_SHORT must be at least 2");
      if (IDLE_LONG <= IDLE_SHORT)  $error("IDLE_LONG must exceed IDLE_SHORT");
   end

   logic idle_hit;
   logic pass;

   wkf_idle_counter #(.IDLE_SHORT(IDLE_SHORT), .IDLE_LONG(IDLE_LONG)) u_idle (
      .clk(clk), .rst_n(rst_n), .idle_type_i(idle_type_i), .nine_bit_i(nine_bit_i),
      .start_i(start_i), .frame_done_i(frame_done_i), .bit_tick_i(bit_tick_i),
      .line_i(line_i), .idle_hit_o(idle_hit));

   wkf_sleep_ctrl u_sleep (
      .clk(clk), .rst_n(rst_n), .sleep_req_i(sleep_req_i), .wake_sel_i(wake_sel_i),
      .frame_done_i(frame_done_i), .frame_msb_i(frame_msb_i), .idle_hit_i(idle_hit),
      .asleep_o(asleep_o), .pass_o(pass), .idle_det_o(idle_det_o));

   wkf_data_gate #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_gate (
      .clk(clk), .rst_n(rst_n), .pass_i(pass), .data_i(frame_data_i),
      .vld_o(rx_vld_o), .data_o(rx_data_o));
endmodule

// File: rtl/wake_filter_chk.sv
module wake_filter_chk #(
   parameter int DATA_W  = 9,
   parameter bit REG_OUT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sleep_req_i,
   input logic              wake_sel_i,
   input logic              bit_tick_i,
   input logic              line_i,
   input logic              frame_done_i,
   input logic [DATA_W-1:0] frame_data_i,
   input logic              frame_msb_i,
   input logic              asleep_o,
   input logic              rx_vld_o,
   input logic [DATA_W-1:0] rx_data_o,
   input logic              idle_det_o
);
   // R3: a sleep request always leaves the node asleep
   assert_sleep_enter_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_req_i |=> asleep_o);

   // R3: sleep only starts on request
   assert_sleep_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(asleep_o) |-> $past(sleep_req_i));

   // R8: a low tick can never complete an idle period
   assert_low_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_tick_i && !line_i) |=> !idle_det_o);

   // R9: idle pulse lasts one cycle
   assert_idle_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      idle_det_o |=> !idle_det_o);

   // R4: no idle pulse from a period that ended while asleep
   assert_idle_awake_R4: assert property (@(posedge clk) disable iff (!rst_n)
      idle_det_o |-> !$past(asleep_o));

   generate
      if (REG_OUT) begin : g_reg_chk
         // R2: awake frames are delivered with their data
         assert_awake_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!asleep_o && frame_done_i) |=> (rx_vld_o && rx_data_o == $past(frame_data_i)));

         // R3: blocked frames while asleep
         assert_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (asleep_o && frame_done_i && !(wake_sel_i && frame_msb_i)) |=> !rx_vld_o);

         // R5: address mark wakes and is delivered
         assert_addr_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (asleep_o && wake_sel_i && frame_done_i && frame_msb_i && !sleep_req_i)
            |=> (!asleep_o && rx_vld_o));
      end
   endgenerate
endmodule

bind wake_filter wake_filter_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_chk (
   .clk(clk), .rst_n(rst_n), .sleep_req_i(sleep_req_i), .wake_sel_i(wake_sel_i),
   .bit_tick_i(bit_tick_i), .line_i(line_i), .frame_done_i(frame_done_i),
   .frame_data_i(frame_data_i), .frame_msb_i(frame_msb_i), .asleep_o(asleep_o),
   .rx_vld_o(rx_vld_o), .rx_data_o(rx_data_o), .idle_det_o(idle_det_o));

// File: tb/tb_wake_filter.sv
`timescale 1ns/1ps
module tb_wake_filter;
   localparam int DW = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sleep_req_i = 0, wake_sel_i = 0, idle_type_i = 0, nine_bit_i = 0;
   logic          start_i = 0, bit_tick_i = 0, line_i = 1, frame_done_i = 0, frame_msb_i = 0;
   logic [DW-1:0] frame_data_i = '0;
   logic          asleep_o, rx_vld_o, idle_det_o;
   logic [DW-1:0] rx_data_o;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 0;

   always #4 clk = ~clk;

   wake_filter dut (.*);

   task automatic check(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   // One tick; returns idle_det_o observed in the cycle after it
   task automatic tick(input logic lvl, output logic det);
      @(negedge clk); bit_tick_i = 1; line_i = lvl;
      @(negedge clk); det = idle_det_o; bit_tick_i = 0; line_i = 1;
   endtask

   task automatic ticks_high(input int n, output int dets, output logic last_det);
      logic d;
      dets = 0; last_det = 0;
      for (int i = 0; i < n; i++) begin
         tick(1'b1, d);
         dets += d;
         last_det = d;
      end
   endtask

   task automatic pulse_start();
      @(negedge clk); start_i = 1;
      @(negedge clk); start_i = 0;
   endtask

   // Frame; returns rx_vld_o and rx_data_o from the cycle after it
   task automatic frame(input logic [DW-1:0] d, input logic sreq,
                        output logic v, output logic [DW-1:0] q);
      @(negedge clk); frame_done_i = 1; frame_data_i = d; frame_msb_i = d[DW-1]; sleep_req_i = sreq;
      @(negedge clk); v = rx_vld_o; q = rx_data_o;
      frame_done_i = 0; sleep_req_i = 0; frame_msb_i = 0;
   endtask

   task automatic go_sleep();
      @(negedge clk); sleep_req_i = 1;
      @(negedge clk); sleep_req_i = 0;
      check("R3 asleep after request", asleep_o, 1);
   endtask

   task automatic t_reset();
      check("R1 asleep_o reset", asleep_o, 0);
      check("R1 rx_vld_o reset", rx_vld_o, 0);
      check("R1 idle_det_o reset", idle_det_o, 0);
   endtask

   task automatic t_awake_pass();
      logic v; logic [DW-1:0] q;
      frame(9'h0A5, 0, v, q);
      check("R2 valid awake", v, 1);
      check("R2 data awake", q, 9'h0A5);
      @(negedge clk);
      check("R2 valid one cycle", rx_vld_o, 0);
      frame(9'h13C, 0, v, q);
      check("R2 second data", q, 9'h13C);
   endtask

   task automatic t_addr_wake();
      logic v; logic [DW-1:0] q;
      wake_sel_i = 1;
      go_sleep();
      frame(9'h055, 0, v, q);
      check("R3 blocked frame", v, 0);
      check("R5 msb0 keeps sleep", asleep_o, 1);
      frame(9'h1C3, 0, v, q);
      check("R5 address frame valid", v, 1);
      check("R5 address frame data", q, 9'h1C3);
      check("R5 woken", asleep_o, 0);
   endtask

   task automatic t_idle_len_short();
      int n; logic l;
      wake_sel_i = 0; idle_type_i = 0; nine_bit_i = 0;
      pulse_start();
      ticks_high(9, n, l);
      check("R6 no flag after 9 ticks", n, 0);
      ticks_high(1, n, l);
      check("R6 flag on 10th tick", l, 1);
      ticks_high(12, n, l);
      check("R9 no repeat flag", n, 0);
   endtask

   task automatic t_low_resets();
      int n; logic l; logic d;
      pulse_start();
      ticks_high(5, n, l);
      tick(1'b0, d);
      check("R8 low tick no flag", d, 0);
      ticks_high(9, n, l);
      check("R8 count restarted", n, 0);
      ticks_high(1, n, l);
      check("R8 flag after 10 fresh", l, 1);
   endtask

   task automatic t_idle_len_long();
      int n; logic l;
      nine_bit_i = 1;
      pulse_start();
      ticks_high(10, n, l);
      check("R6 nine-bit no flag at 10", n, 0);
      ticks_high(1, n, l);
      check("R6 nine-bit flag at 11", l, 1);
      nine_bit_i = 0;
   endtask

   task automatic t_after_stop();
      int n; logic l; logic v; logic [DW-1:0] q;
      idle_type_i = 1;
      pulse_start();
      ticks_high(12, n, l);
      check("R7 disarmed by start", n, 0);
      frame(9'h011, 0, v, q);
      ticks_high(9, n, l);
      check("R7 armed no early flag", n, 0);
      ticks_high(1, n, l);
      check("R7 flag after stop arming", l, 1);
      idle_type_i = 0;
   endtask

   task automatic t_idle_wake();
      int n; logic l; logic v; logic [DW-1:0] q;
      wake_sel_i = 0;
      go_sleep();
      frame(9'h1FF, 0, v, q);
      check("R5 msb ignored in idle mode valid", v, 0);
      check("R5 msb ignored in idle mode sleep", asleep_o, 1);
      pulse_start();
      ticks_high(9, n, l);
      check("R4 still asleep before idle", asleep_o, 1);
      ticks_high(1, n, l);
      check("R4 woken by idle", asleep_o, 0);
      check("R4 no flag while asleep", l, 0);
   endtask

   task automatic t_clash();
      logic v; logic [DW-1:0] q;
      wake_sel_i = 1;
      go_sleep();
      frame(9'h1AA, 1, v, q);
      check("R10 sleep wins", asleep_o, 1);
      check("R10 frame still passed", v, 1);
      frame(9'h1BB, 0, v, q);
      check("R10 later wake", asleep_o, 0);
      wake_sel_i = 0;
   endtask

   initial begin
      #800000;
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_awake_pass();
      t_addr_wake();
      t_idle_len_short();
      t_low_resets();
      t_idle_len_long();
      t_after_stop();
      t_idle_wake();
      t_clash();
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule